// File: doc/BRIEF.md
# QAM Symbol-to-Byte Framer with Differential Quadrant Decoding

This block sits behind a QAM slicer and turns hard-decided symbols into a byte stream cut into fixed-length error-correction frames. Each symbol comes in as a 2-bit quadrant number and six in-quadrant bits. A 3-bit constellation select says how many of those bits count. The quadrant is decoded differentially against the previous symbol, so the output does not change if the whole constellation is rotated by a multiple of 90 degrees.

The decoded bits are packed most-significant first into bytes, with no regard for symbol boundaries. A frame aligner then looks for the sync byte at every bit offset. It verifies that the sync byte repeats at the frame spacing before it declares lock. While locked it marks the first byte of each frame and keeps lock through isolated sync errors. A change of constellation throws away any partly packed bits and restarts the search.

Top module: `qam_byte_framer`

## Requirements
- R1: `cons_sel` values 0, 1, 2, 3 and 4 give 4, 5, 6, 7 and 8 bits per symbol. Values 5 to 7 behave as 4. A symbol with N bits uses the two decoded quadrant bits as its top bits and `inq[N-3:0]` below them. Higher `inq` bits are ignored.
- R2: The decoded quadrant pair is the Gray code of (`quad` − previous accepted `quad`) mod 4: 0→00, 1→01, 2→11, 3→10. The previous quadrant is 0 after reset. A constant rotation of all quadrants after the first symbol leaves the bytes unchanged.
- R3: Symbol bits enter the byte packer most-significant first. A byte is formed whenever 8 bits have built up, and leftover bits carry into the next byte.
- R4: While hunting, the aligner compares each pair of consecutive packed bytes with the sync pattern at bit offsets 0 to 7 and takes the lowest matching offset. Output bytes are the packed stream shifted by the chosen offset, one packed byte behind.
- R5: A sync byte is `SYNC_BYTE` (default 0x47) or its bitwise inverse (0xB8). `locked` rises on the third sync in a row found at `FRAME_LEN`-byte spacing. Hunting only starts the count.
- R6: `frame_start` is high with `byte_vld` on the first byte of a frame, and only if the aligner was locked when that byte was output.
- R7: Lock is dropped after three consecutive frames whose first byte is not a sync byte. A sync byte in between clears the miss count.
- R8: A change of `cons_sel` discards the partly packed bits and returns the aligner to hunting, so `locked` is low on the next cycle.
- R9: After reset, `byte_vld`, `frame_start`, `locked` and `byte_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Symbol strobe |
| quad | input | 2 | Quadrant number of the symbol (binary) |
| inq | input | 6 | In-quadrant bits, right aligned |
| cons_sel | input | 3 | Constellation select (0 = 16 points ... 4 = 256 points) |
| byte_vld | output | 1 | Output byte strobe |
| byte_data | output | 8 | Aligned output byte |
| frame_start | output | 1 | First byte of a frame while locked |
| locked | output | 1 | Frame alignment locked |

## Verification
The bench builds the framer with `FRAME_LEN` = 12 and keeps the default three-frame lock and drop counts. Short frames allow many frame periods per run. Within a few thousand cycles the bench covers every constellation width, including a saturated select code, and several bit offsets of the first sync byte. It also covers lock gain, survival of two sync misses, loss after three misses, a failed verification, and relock after each flush. The payload bytes cannot look like a sync byte at any offset, so every output byte and every frame flag can be predicted from bit arithmetic.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

    typedef enum logic [1:0] {
        ALN_HUNT   = 2'd0,
        ALN_VERIFY = 2'd1,
        ALN_LOCK   = 2'd2
    } aln_state_e;

    // One decoded symbol: bit count and right-aligned bits
    typedef struct packed {
        logic [3:0] nbits;
        logic [7:0] bits;
    } sym_word_t;

    function automatic logic [3:0] bits_per_sym(input logic [2:0] sel);
        return (sel > 3'd4) ? 4'd4 : 4'd4 + {1'b0, sel};
    endfunction

    function automatic logic [1:0] rot_to_gray(input logic [1:0] r);
        return {r[1], r[1] ^ r[0]};
    endfunction

    function automatic logic is_sync(input logic [7:0] b, input logic [7:0] pat);
        return (b == pat) || (b == ~pat);
    endfunction

endpackage

// File: rtl/qdf_diff_dec.sv
module qdf_diff_dec
    import qdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_vld,
    input  logic [1:0] quad,
    output logic [1:0] rot_gray
);
    logic [1:0] prev_q;

    always_comb rot_gray = rot_to_gray(quad - prev_q);

    always_ff @(posedge clk) begin
        if (rst)          prev_q <= 2'd0;
        else if (sym_vld) prev_q <= quad;
    end

    // R2: no quadrant change means zero rotation code
    p_same_quad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && quad == prev_q) |-> rot_gray == 2'b00);

endmodule

// File: rtl/qdf_packer.sv
module qdf_packer
    import qdf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      in_vld,
    input  sym_word_t in_word,
    output logic      raw_vld,
    output logic [7:0] raw_byte
);
    logic [7:0]  acc, base_acc, nxt_acc, byte_c;
    logic [3:0]  cnt, base_cnt, nxt_cnt;
    logic [4:0]  total;
    logic [15:0] ext, keep_mask;
    logic        hit;

    always_comb begin
        base_cnt  = flush ? 4'd0 : cnt;
        base_acc  = flush ? 8'd0 : acc;
        ext       = ({8'd0, base_acc} << in_word.nbits) | {8'd0, in_word.bits};
        total     = {1'b0, base_cnt} + {1'b0, in_word.nbits};
        hit       = 1'b0;
        byte_c    = 8'd0;
        nxt_cnt   = base_cnt;
        nxt_acc   = base_acc;
        keep_mask = 16'd0;
        if (in_vld) begin
            if (total >= 5'd8) begin
                hit       = 1'b1;
                byte_c    = 8'(ext >> (total - 5'd8));
                nxt_cnt   = 4'(total - 5'd8);
                keep_mask = (16'd1 << nxt_cnt) - 16'd1;
                nxt_acc   = 8'(ext & keep_mask);
            end else begin
                nxt_cnt = total[3:0];
                nxt_acc = ext[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= 8'd0;
            cnt      <= 4'd0;
            raw_vld  <= 1'b0;
            raw_byte <= 8'd0;
        end else begin
            acc      <= nxt_acc;
            cnt      <= nxt_cnt;
            raw_vld  <= hit;
            raw_byte <= byte_c;
        end
    end

    // R3: never more than a byte's worth left over
    p_cnt_below_byte_r3: assert property (@(posedge clk) disable iff (rst)
        cnt < 4'd8);
    // R8: a flush with no symbol leaves the packer empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        (flush && !in_vld) |=> cnt == 4'd0);

endmodule

// File: rtl/qdf_aligner.sv
module qdf_aligner
    import qdf_pkg::*;
#(
    parameter int         FRAME_LEN   = 204,
    parameter int         LOCK_HITS   = 3,
    parameter int         DROP_MISSES = 3,
    parameter logic [7:0] SYNC_BYTE   = 8'h47
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       raw_vld,
    input  logic [7:0] raw_byte,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_start,
    output logic       locked
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam int HIT_W = $clog2(LOCK_HITS + 1);
    localparam int MIS_W = $clog2(DROP_MISSES + 1);

    aln_state_e       state;
    logic [2:0]       slip, hunt_slip;
    logic [7:0]       prev;
    logic             have_prev, hunt_hit, cur_sync;
    logic [POS_W-1:0] pos;
    logic [HIT_W-1:0] hits;
    logic [MIS_W-1:0] misses;
    logic [15:0]      pair;
    logic [7:0]       win [8];
    logic [7:0]       cur;

    always_comb begin
        pair      = {prev, raw_byte};
        hunt_hit  = 1'b0;
        hunt_slip = 3'd0;
        for (int s = 0; s < 8; s++) win[s] = pair[15-s -: 8];
        for (int s = 7; s >= 0; s--) begin
            if (is_sync(win[s], SYNC_BYTE)) begin
                hunt_hit  = 1'b1;
                hunt_slip = 3'(s);
            end
        end
        cur      = win[slip];
        cur_sync = is_sync(cur, SYNC_BYTE);
    end

    assign locked = (state == ALN_LOCK);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state       <= ALN_HUNT;
            slip        <= 3'd0;
            prev        <= 8'd0;
            have_prev   <= 1'b0;
            pos         <= '0;
            hits        <= '0;
            misses      <= '0;
            byte_vld    <= 1'b0;
            frame_start <= 1'b0;
            if (rst) byte_data <= 8'd0;
        end else begin
            byte_vld    <= 1'b0;
            frame_start <= 1'b0;
            if (raw_vld) begin
                prev      <= raw_byte;
                have_prev <= 1'b1;
                if (have_prev) begin
                    byte_vld <= 1'b1;
                    if (state == ALN_HUNT) begin
                        if (hunt_hit) begin
                            slip      <= hunt_slip;
                            byte_data <= win[hunt_slip];
                            pos       <= POS_W'(1);
                            hits      <= HIT_W'(1);
                            state     <= ALN_VERIFY;
                        end else begin
                            byte_data <= cur;
                        end
                    end else begin
                        byte_data   <= cur;
                        frame_start <= (state == ALN_LOCK) && (pos == '0);
                        pos <= (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
                        if (pos == '0) begin
                            if (state == ALN_VERIFY) begin
                                if (!cur_sync) begin
                                    state <= ALN_HUNT;
                                end else begin
                                    hits <= hits + 1'b1;
                                    if (hits + 1'b1 == HIT_W'(LOCK_HITS)) begin
                                        state  <= ALN_LOCK;
                                        misses <= '0;
                                    end
                                end
                            end else if (cur_sync) begin
                                misses <= '0;
                            end else begin
                                misses <= misses + 1'b1;
                                if (misses + 1'b1 == MIS_W'(DROP_MISSES)) begin
                                    state  <= ALN_HUNT;
                                    misses <= '0;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    // R6: a frame flag always comes with a byte
    p_fs_with_byte_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> byte_vld);
    // R5: lock is entered on a sync byte
    p_lock_on_sync_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (byte_vld && is_sync(byte_data, SYNC_BYTE)));
    // R8: flush restarts the search
    p_flush_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !locked);

endmodule

// File: rtl/qam_byte_framer.sv
module qam_byte_framer
    import qdf_pkg::*;
#(
    parameter int         FRAME_LEN   = 204,
    parameter int         LOCK_HITS   = 3,
    parameter int         DROP_MISSES = 3,
    parameter logic [7:0] SYNC_BYTE   = 8'h47
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_vld,
    input  logic [1:0] quad,
    input  logic [5:0] inq,
    input  logic [2:0] cons_sel,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_start,
    output logic       locked
);
    logic [2:0] cons_q;
    logic       flush;
    logic [1:0] rot_gray;
    logic [3:0] nb;
    logic [7:0] low_mask;
    sym_word_t  word;
    logic       raw_vld;
    logic [7:0] raw_byte;

    always_ff @(posedge clk) begin
        if (rst) cons_q <= 3'd0;
        else     cons_q <= cons_sel;
    end

    assign flush = (cons_sel != cons_q);

    qdf_diff_dec u_diff (
        .clk      (clk),
        .rst      (rst),
        .sym_vld  (sym_vld),
        .quad     (quad),
        .rot_gray (rot_gray)
    );

    always_comb begin
        nb         = bits_per_sym(cons_sel);
        low_mask   = (8'd1 << (nb - 4'd2)) - 8'd1;
        word.nbits = nb;
        word.bits  = ({6'd0, rot_gray} << (nb - 4'd2)) | ({2'd0, inq} & low_mask);
    end

    qdf_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_vld   (sym_vld),
        .in_word  (word),
        .raw_vld  (raw_vld),
        .raw_byte (raw_byte)
    );

    qdf_aligner #(
        .FRAME_LEN   (FRAME_LEN),
        .LOCK_HITS   (LOCK_HITS),
        .DROP_MISSES (DROP_MISSES),
        .SYNC_BYTE   (SYNC_BYTE)
    ) u_align (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .raw_vld     (raw_vld),
        .raw_byte    (raw_byte),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .frame_start (frame_start),
        .locked      (locked)
    );

    // R1: symbol width stays within the supported range
    p_width_range_r1: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> (word.nbits >= 4'd4 && word.nbits <= 4'd8));

endmodule

// File: tb/qam_byte_framer_tb_top.sv
module qam_byte_framer_tb_top;
    localparam int FL = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_vld = 1'b0;
    logic [1:0] quad = 2'd0;
    logic [5:0] inq = 6'd0;
    logic [2:0] cons_sel = 3'd0;
    logic       byte_vld, frame_start, locked;
    logic [7:0] byte_data;

    always #2.5 clk = ~clk;

    qam_byte_framer #(.FRAME_LEN(FL)) dut_i (
        .clk(clk), .rst(rst), .sym_vld(sym_vld), .quad(quad), .inq(inq),
        .cons_sel(cons_sel), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_start(frame_start), .locked(locked)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] rx_data [0:1023];
    bit         rx_fs   [0:1023];
    int         rx_n = 0;

    always @(negedge clk) begin
        if (!rst && byte_vld && rx_n < 1024) begin
            rx_data[rx_n] <= byte_data;
            rx_fs[rx_n]   <= frame_start;
            rx_n          <= rx_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    bit  bits [0:4095];
    int  tq = 0;
    bit  exp_fs [0:15];
    bit  exp_lock;

    function automatic int g2r(input int g);
        case (g)
            0: return 0;
            1: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic run(input int r, input int sel, input int k, input int nfr,
                       input int badmask, input bit gaps);
        int nb, n, base, st, hits, miss, padded, rcount;
        nb = 0;
        for (int i = 0; i < k; i++) bits[nb++] = 1'b0;
        for (int f = 0; f < nfr; f++) begin
            for (int j = 0; j < FL; j++) begin
                logic [7:0] b;
                if (j == 0) begin
                    if ((badmask >> f) & 1) b = 8'h00;
                    else b = (f % 3 == 2) ? 8'hB8 : 8'h47;
                end else begin
                    b = 8'((f * 5 + j * 3 + r) & 15);
                end
                for (int t = 7; t >= 0; t--) bits[nb++] = b[t];
            end
        end
        n = (sel > 4) ? 4 : 4 + sel;
        padded = ((nb + n - 1) / n) * n;
        for (int i = nb; i < padded; i++) bits[i] = 1'b0;
        // expected frame flags and lock, per R5/R6/R7
        st = 0; hits = 0; miss = 0;
        for (int f = 0; f < nfr; f++) begin
            bit good;
            good = !((badmask >> f) & 1);
            exp_fs[f] = (st == 2);
            if (st == 0) begin
                if (good) begin st = 1; hits = 1; end
            end else if (st == 1) begin
                if (good) begin hits++; if (hits == 3) begin st = 2; miss = 0; end end
                else st = 0;
            end else begin
                if (good) miss = 0;
                else begin miss++; if (miss == 3) begin st = 0; miss = 0; end end
            end
        end
        exp_lock = (st == 2);
        base = rx_n;
        if (r > 0) begin
            @(negedge clk);
            tq = (tq + 3) & 3;
            sym_vld = 1'b1; quad = 2'(tq); inq = 6'h15;
            cons_sel = 3'((sel + 1) % 5);
            @(negedge clk);
            chk(locked == 1'b0, "R8 unlocked after select change", locked, 0);
            sym_vld = 1'b0;
        end
        for (int p = 0; p < padded; p += n) begin
            int g, v;
            @(negedge clk);
            if (gaps && ((p / n) % 4 == 3)) begin
                sym_vld = 1'b0;
                @(negedge clk);
            end
            g = bits[p] * 2 + bits[p + 1];
            v = 0;
            for (int t = 2; t < n; t++) v = v * 2 + bits[p + t];
            tq = (tq + g2r(g)) & 3;
            sym_vld  = 1'b1;
            quad     = 2'(tq);
            inq      = 6'(v | (6'h3F << (n - 2)));
            cons_sel = 3'(sel);
        end
        @(negedge clk);
        sym_vld = 1'b0;
        repeat (8) @(negedge clk);
        rcount = padded / 8 - 1;
        chk(rx_n - base == rcount, "R3 output byte count", rx_n - base, rcount);
        for (int i = 0; i < rcount && i < rx_n - base; i++) begin
            logic [7:0] e;
            e = 8'd0;
            for (int t = 0; t < 8; t++) e = {e[6:0], bits[8 * i + k + t]};
            chk(rx_data[base + i] == e, "R1/R2/R3/R4 byte value",
                rx_data[base + i], e);
            if (i % FL == 0)
                chk(rx_fs[base + i] == exp_fs[i / FL], "R6 frame_start at frame head",
                    rx_fs[base + i], exp_fs[i / FL]);
            else
                chk(rx_fs[base + i] == 1'b0, "R6 frame_start off mid-frame",
                    rx_fs[base + i], 0);
        end
        chk(locked == exp_lock, "R5/R7 final lock state", locked, exp_lock);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(byte_vld == 1'b0, "R9 byte_vld at reset", byte_vld, 0);
        chk(frame_start == 1'b0, "R9 frame_start at reset", frame_start, 0);
        chk(locked == 1'b0, "R9 locked at reset", locked, 0);
        chk(byte_data == 8'd0, "R9 byte_data at reset", byte_data, 0);
        // R2 reset reference quadrant 0, R5 lock on both sync polarities
        run(0, 4, 0, 6, 16'h0000, 1'b0);
        // R7 two misses tolerated, 16-point width, R4 offset 3
        run(1, 0, 3, 8, 16'h0030, 1'b1);
        // R7 three misses drop lock, then relock
        run(2, 1, 5, 10, 16'h0070, 1'b0);
        // R5 failed verification restarts the hunt, R4 offset 7
        run(3, 2, 7, 7, 16'h0002, 1'b1);
        run(4, 3, 1, 6, 16'h0000, 1'b0);
        // R1 saturated select code behaves as 16 points
        run(5, 6, 2, 5, 16'h0000, 1'b1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule